// File: doc/BRIEF.md
# DMA Channel Run-State Controller

This block decides, for a small group of DMA channels, whether each one is idle, moving data or held. Software sets two layers of control. The global layer is an all-channel enable, a multi-bit all-channel halt field and an arbitration mode. The per-channel layer is an enable bit and a pause bit for each channel. From these controls, and from two strobes returned by each channel's data engine, the block runs one three-state machine per channel. The states are Disable, Transfer and Pause. Each channel also carries a 3-bit status code.

The strobes are a transfer-gap strobe, which marks the boundary between two transfers, and a completion strobe. The block grants the shared bus to one active channel at a time. The grant moves only at a transfer gap. The block also raises a stopped flag once a halt is requested and no channel is still moving data. A held channel is allowed to finish the transfer in progress before it parks. A finished channel keeps its completion code until it is actually restarted.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset every channel is in Disable, `active` and `grant` are all zero, every status code is 3'b000, `stopped` is 0 and `arb_mode` is 0.
- R2: A channel in Disable or Pause enters Transfer on the next clock edge only when four conditions all hold: `all_en`=1, `all_halt`=0, its `ch_en`=1 and its `ch_pause`=0. If any one of them is missing, a Disabled channel stays in Disable.
- R3: Channel enables may be set before `all_en`. When `all_en` rises, every channel that meets the condition of R2 becomes active on the same edge.
- R4: A completion strobe on a channel in Transfer moves it to Disable and sets its status to 3'b101.
- R5: A pause request comes from a nonzero `all_halt` or from the channel's `ch_pause`. If the channel does not hold the grant, or if its gap strobe is high, it enters Pause at the next edge. If it holds the grant and no gap strobe is present, it stays in Transfer until its gap strobe arrives. On entering Pause the status becomes 3'b111.
- R6: When the pause request is cancelled and the condition of R2 holds, a paused channel returns to Transfer with status 3'b000.
- R7: Pause, halt or enable changes aimed at a channel in Disable leave its state and its status code unchanged, so a 3'b101 completion code stays visible.
- R8: `stopped` is 1 after an edge at which `all_halt` is nonzero and no channel remains in Transfer. It is 0 after any edge at which `all_halt` is zero.
- R9: A write on `prio_wr` updates `arb_mode` only when `all_en` is 0 in that cycle. Otherwise it is ignored.
- R10: `grant` is one-hot or zero, and it names only an active channel. In mode 0 or 3 (round robin), a gap strobe from the owner passes the grant to the next active channel in ascending index order, wrapping around. With no previous owner, the search starts at channel 0.
- R11: In mode 1 the lowest-indexed active channel wins, and in mode 2 the highest-indexed one wins. The choice is made whenever the owner signals a gap or stops being active.
- R12: A Disabled channel that still shows 3'b101 and meets the condition of R2 re-enters Transfer with status 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| all_en | input | 1 | All-channel enable |
| all_halt | input | HALT_W | All-channel halt field, nonzero requests a pause |
| prio_wr | input | 1 | Arbitration mode write strobe |
| prio_wdata | input | 2 | Arbitration mode write value |
| ch_en | input | NCH | Per-channel enable |
| ch_pause | input | NCH | Per-channel pause request |
| xfer_gap | input | NCH | Per-channel transfer-gap strobe |
| xfer_done | input | NCH | Per-channel completion strobe |
| active | output | NCH | Channel is in Transfer |
| grant | output | NCH | One-hot bus grant |
| status | output | 3*NCH | Status codes, channel i at bits [3i+2:3i] |
| stopped | output | 1 | All channels stopped under a halt |
| arb_mode | output | 2 | Current arbitration mode |

## Verification
The bench drives a halt while one channel holds the grant mid-transfer. A design that paused that channel at once, instead of at its gap strobe, would drop `active` one vector too early and raise `stopped` early. It sends pause and enable changes to a channel that has completed. A design that rewrote the status would lose the 3'b101 code, and one that restarted the channel without its enable would show it active. It writes the arbitration mode while `all_en` is high, where a missing lock shows up as a changed `arb_mode`. It then repeats gap strobes under each fixed mode, where a round-robin fallback would move the grant away from the lowest- or highest-indexed channel.

// File: rtl/dma_cc_pkg.sv
package dma_cc_pkg;
   typedef enum logic [1:0] {
      CH_DIS   = 2'd0,
      CH_XFER  = 2'd1,
      CH_PAUSE = 2'd2
   } ch_state_e;

   localparam int          STAT_W  = 3;
   localparam int          MODE_W  = 2;
   localparam logic [2:0]  ST_IDLE = 3'b000;
   localparam logic [2:0]  ST_DONE = 3'b101;
   localparam logic [2:0]  ST_HELD = 3'b111;

   localparam logic [1:0]  ARB_RR   = 2'd0;
   localparam logic [1:0]  ARB_LOW  = 2'd1;
   localparam logic [1:0]  ARB_HIGH = 2'd2;
endpackage

// File: rtl/dma_prio_reg.sv
module dma_prio_reg
   import dma_cc_pkg::*;
#(
   parameter logic [MODE_W-1:0] RESET_MODE = ARB_RR
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              locked,
   input  logic [MODE_W-1:0] wdata,
   output logic [MODE_W-1:0] mode_o
);
   logic [MODE_W-1:0] mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode_q <= RESET_MODE;
      else if (wr && !locked)
         mode_q <= wdata;
   end

   assign mode_o = mode_q;
endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
   import dma_cc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_ok,
   input  logic              hold_req,
   input  logic              kill,
   input  logic              owner,
   input  logic              gap,
   input  logic              done,
   output logic              xfer_o,
   output logic              xfer_nx_o,
   output logic [STAT_W-1:0] status_o
);
   ch_state_e         st_q, st_n;
   logic [STAT_W-1:0] stat_q, stat_n;
   logic              at_gap;

   // A channel not owning the bus has no transfer in flight.
   assign at_gap = !owner || gap;

   always_comb begin
      st_n   = st_q;
      stat_n = stat_q;
      unique case (st_q)
         CH_DIS: begin
            if (run_ok) begin
               st_n   = CH_XFER;
               stat_n = ST_IDLE;
            end
         end
         CH_XFER: begin
            if (done) begin
               st_n   = CH_DIS;
               stat_n = ST_DONE;
            end else if (kill) begin
               st_n   = CH_DIS;
            end else if (hold_req && at_gap) begin
               st_n   = CH_PAUSE;
               stat_n = ST_HELD;
            end
         end
         CH_PAUSE: begin
            if (kill) begin
               st_n   = CH_DIS;
            end else if (run_ok) begin
               st_n   = CH_XFER;
               stat_n = ST_IDLE;
            end
         end
         default: begin
            st_n   = CH_DIS;
            stat_n = ST_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= CH_DIS;
         stat_q <= ST_IDLE;
      end else begin
         st_q   <= st_n;
         stat_q <= stat_n;
      end
   end

   assign xfer_o    = (st_q == CH_XFER);
   assign xfer_nx_o = (st_n == CH_XFER);
   assign status_o  = stat_q;
endmodule

// File: rtl/dma_chan_arb.sv
module dma_chan_arb
   import dma_cc_pkg::*;
#(
   parameter int NCH = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode,
   input  logic [NCH-1:0]    req,
   input  logic [NCH-1:0]    gap,
   output logic [NCH-1:0]    grant_o
);
   localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

   logic [NCH-1:0]   grant_q, grant_n;
   logic [IDX_W-1:0] own_idx;
   logic             keep;

   always_comb begin
      own_idx = IDX_W'(NCH - 1);
      for (int i = 0; i < NCH; i++)
         if (grant_q[i]) own_idx = IDX_W'(i);
   end

   assign keep = (|(grant_q & req)) && !(|(grant_q & gap));

   always_comb begin
      logic found;
      found   = 1'b0;
      grant_n = '0;
      if (keep) begin
         grant_n = grant_q;
      end else begin
         case (mode)
            ARB_LOW: begin
               for (int i = 0; i < NCH; i++)
                  if (!found && req[i]) begin
                     grant_n[i] = 1'b1;
                     found      = 1'b1;
                  end
            end
            ARB_HIGH: begin
               for (int i = NCH - 1; i >= 0; i--)
                  if (!found && req[i]) begin
                     grant_n[i] = 1'b1;
                     found      = 1'b1;
                  end
            end
            default: begin
               for (int k = 1; k <= NCH; k++) begin
                  int j;
                  j = (int'(own_idx) + k) % NCH;
                  if (!found && req[j]) begin
                     grant_n[j] = 1'b1;
                     found      = 1'b1;
                  end
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) grant_q <= '0;
      else        grant_q <= grant_n;
   end

   assign grant_o = grant_q;
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
   import dma_cc_pkg::*;
#(
   parameter int NCH    = 3,
   parameter int HALT_W = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  all_en,
   input  logic [HALT_W-1:0]     all_halt,
   input  logic                  prio_wr,
   input  logic [MODE_W-1:0]     prio_wdata,
   input  logic [NCH-1:0]        ch_en,
   input  logic [NCH-1:0]        ch_pause,
   input  logic [NCH-1:0]        xfer_gap,
   input  logic [NCH-1:0]        xfer_done,
   output logic [NCH-1:0]        active,
   output logic [NCH-1:0]        grant,
   output logic [STAT_W*NCH-1:0] status,
   output logic                  stopped,
   output logic [MODE_W-1:0]     arb_mode
);
   if (NCH < 2 || NCH > 32) begin : g_bad_nch
      $error("dma_chan_ctrl: NCH must be in 2..32");
   end
   if (HALT_W < 1) begin : g_bad_halt
      $error("dma_chan_ctrl: HALT_W must be at least 1");
   end

   logic           halt_any;
   logic [NCH-1:0] act_nx;
   logic           stopped_q;

   assign halt_any = |all_halt;

   dma_prio_reg u_prio (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (prio_wr),
      .locked (all_en),
      .wdata  (prio_wdata),
      .mode_o (arb_mode)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic run_ok, hold_req, kill;
      assign kill     = !all_en || !ch_en[c];
      assign hold_req = halt_any || ch_pause[c];
      assign run_ok   = !kill && !hold_req;

      dma_chan_fsm u_fsm (
         .clk       (clk),
         .rst_n     (rst_n),
         .run_ok    (run_ok),
         .hold_req  (hold_req),
         .kill      (kill),
         .owner     (grant[c]),
         .gap       (xfer_gap[c]),
         .done      (xfer_done[c]),
         .xfer_o    (active[c]),
         .xfer_nx_o (act_nx[c]),
         .status_o  (status[STAT_W*c +: STAT_W])
      );
   end

   dma_chan_arb #(.NCH(NCH)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (arb_mode),
      .req     (act_nx),
      .gap     (xfer_gap),
      .grant_o (grant)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stopped_q <= 1'b0;
      else        stopped_q <= halt_any && (act_nx == '0);
   end

   assign stopped = stopped_q;
endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk #(
   parameter int NCH    = 3,
   parameter int HALT_W = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                all_en,
   input logic [HALT_W-1:0]   all_halt,
   input logic                prio_wr,
   input logic [NCH-1:0]      ch_en,
   input logic [NCH-1:0]      ch_pause,
   input logic [NCH-1:0]      xfer_done,
   input logic [NCH-1:0]      active,
   input logic [NCH-1:0]      grant,
   input logic [3*NCH-1:0]    status,
   input logic                stopped,
   input logic [1:0]          arb_mode
);
   // R10
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R10
   grant_in_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~active) == '0);

   // R8
   stopped_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stopped |-> (active == '0));

   // R9
   mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(all_en) |-> $stable(arb_mode));

   for (genvar c = 0; c < NCH; c++) begin : g_c
      // R4
      done_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (active[c] && xfer_done[c]) |=> (!active[c] && status[3*c +: 3] == 3'b101));

      // R2
      start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(active[c]) |-> $past(all_en && all_halt == '0 && ch_en[c] && !ch_pause[c]));
   end
endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(.NCH(NCH), .HALT_W(HALT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .all_en    (all_en),
   .all_halt  (all_halt),
   .prio_wr   (prio_wr),
   .ch_en     (ch_en),
   .ch_pause  (ch_pause),
   .xfer_done (xfer_done),
   .active    (active),
   .grant     (grant),
   .status    (status),
   .stopped   (stopped),
   .arb_mode  (arb_mode)
);

// File: tb/dma_chan_ctrl_bench.sv
module dma_chan_ctrl_bench;
   localparam int NCH = 3;
   localparam int NV  = 19;
   // all_en, halt[4], en[3], pause[3], gap[3], done[3] | act[3], gnt[3], status[9], stop
   localparam logic [32:0] VEC [NV] = '{
      {1'b0,4'h0,3'b111,3'b000,3'b000,3'b000, 3'b000,3'b000,9'o000,1'b0}, // R3 enables first, no start
      {1'b1,4'h0,3'b111,3'b000,3'b000,3'b000, 3'b111,3'b001,9'o000,1'b0}, // R3 joint start
      {1'b1,4'h0,3'b111,3'b000,3'b001,3'b000, 3'b111,3'b010,9'o000,1'b0}, // R10 rotate
      {1'b1,4'h0,3'b111,3'b000,3'b010,3'b000, 3'b111,3'b100,9'o000,1'b0}, // R10
      {1'b1,4'h0,3'b111,3'b000,3'b100,3'b000, 3'b111,3'b001,9'o000,1'b0}, // R10 wrap
      {1'b1,4'h0,3'b111,3'b000,3'b000,3'b100, 3'b011,3'b001,9'o500,1'b0}, // R4 completion
      {1'b1,4'h0,3'b011,3'b000,3'b001,3'b000, 3'b011,3'b010,9'o500,1'b0}, // R7 R10
      {1'b1,4'h1,3'b011,3'b000,3'b000,3'b000, 3'b010,3'b010,9'o507,1'b0}, // R5 owner waits
      {1'b1,4'h1,3'b011,3'b000,3'b010,3'b000, 3'b000,3'b000,9'o577,1'b1}, // R5 R8
      {1'b1,4'h0,3'b011,3'b000,3'b000,3'b000, 3'b011,3'b001,9'o500,1'b0}, // R6 R7 R8
      {1'b1,4'h0,3'b011,3'b001,3'b000,3'b000, 3'b011,3'b001,9'o500,1'b0}, // R5 owner mid
      {1'b1,4'h0,3'b011,3'b001,3'b001,3'b000, 3'b010,3'b010,9'o507,1'b0}, // R5 at gap
      {1'b1,4'h0,3'b011,3'b101,3'b000,3'b000, 3'b010,3'b010,9'o507,1'b0}, // R7 pause to done ch
      {1'b1,4'h0,3'b111,3'b000,3'b000,3'b000, 3'b111,3'b010,9'o000,1'b0}, // R6 R12
      {1'b0,4'h0,3'b111,3'b000,3'b000,3'b000, 3'b000,3'b000,9'o000,1'b0}, // R2 global off
      {1'b1,4'h2,3'b111,3'b000,3'b000,3'b000, 3'b000,3'b000,9'o000,1'b1}, // R2 halt blocks, R8
      {1'b1,4'h0,3'b111,3'b111,3'b000,3'b000, 3'b000,3'b000,9'o000,1'b0}, // R2 pause blocks
      {1'b1,4'h0,3'b000,3'b000,3'b000,3'b000, 3'b000,3'b000,9'o000,1'b0}, // R2 enable blocks
      {1'b1,4'h0,3'b111,3'b000,3'b000,3'b000, 3'b111,3'b001,9'o000,1'b0}  // R2 all met
   };

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           all_en = 1'b0;
   logic [3:0]     all_halt = '0;
   logic           prio_wr = 1'b0;
   logic [1:0]     prio_wdata = '0;
   logic [NCH-1:0] ch_en = '0, ch_pause = '0, xfer_gap = '0, xfer_done = '0;
   logic [NCH-1:0] active, grant;
   logic [3*NCH-1:0] status;
   logic           stopped;
   logic [1:0]     arb_mode;
   int             n_chk = 0, n_bad = 0;

   always #2 clk = ~clk;

   dma_chan_ctrl u_dma_chan_ctrl (
      .clk(clk), .rst_n(rst_n), .all_en(all_en), .all_halt(all_halt),
      .prio_wr(prio_wr), .prio_wdata(prio_wdata), .ch_en(ch_en),
      .ch_pause(ch_pause), .xfer_gap(xfer_gap), .xfer_done(xfer_done),
      .active(active), .grant(grant), .status(status), .stopped(stopped),
      .arb_mode(arb_mode)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
      @(negedge clk);
   endtask

   task automatic outs(input string req, input logic [2:0] a, input logic [2:0] g,
                       input logic [8:0] s, input logic st);
      check(req, {15'd0, active, grant, status, stopped}, {15'd0, a, g, s, st});
   endtask

   initial begin
      #(4 * 5000);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      check("R1 mode", {30'd0, arb_mode}, 32'd0);
      outs("R1 reset", 3'b000, 3'b000, 9'o000, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         {all_en, all_halt, ch_en, ch_pause, xfer_gap, xfer_done} = VEC[v][32:16];
         step();
         outs($sformatf("vector %0d", v), VEC[v][15:13], VEC[v][12:10], VEC[v][9:1], VEC[v][0]);
      end
      xfer_gap = '0;

      // R9 write while globally enabled is dropped
      prio_wr = 1'b1; prio_wdata = 2'd1;
      step();
      prio_wr = 1'b0;
      check("R9 locked", {30'd0, arb_mode}, 32'd0);

      // R9 write accepted when globally disabled
      all_en = 1'b0;
      step();
      prio_wr = 1'b1; prio_wdata = 2'd1;
      step();
      prio_wr = 1'b0;
      check("R9 open", {30'd0, arb_mode}, 32'd1);

      // R11 lowest index wins, even after its own gap
      all_en = 1'b1;
      step();
      check("R11 low start", {29'd0, grant}, 32'b001);
      xfer_gap = 3'b001;
      step();
      xfer_gap = '0;
      check("R11 low regrant", {29'd0, grant}, 32'b001);

      // R11 highest index wins
      all_en = 1'b0;
      step();
      prio_wr = 1'b1; prio_wdata = 2'd2;
      step();
      prio_wr = 1'b0;
      all_en = 1'b1;
      step();
      check("R11 high start", {29'd0, grant}, 32'b100);
      xfer_gap = 3'b100;
      step();
      xfer_gap = '0;
      check("R11 high regrant", {29'd0, grant}, 32'b100);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule